// File: doc/BRIEF.md
# Register-Mapped Program Memory Reader

This block gives a small 8-bit processor core a way to read words back out of its own program memory through byte-wide registers. Software loads a 13-bit word address as two bytes, then sets a one-bit read strobe in a control register. The block latches the address, issues a single request on a synchronous memory read port of fixed latency, and captures the returned 14-bit word into two read-only data registers. At that same clock edge it drops the strobe. Software polls the strobe and reads the two data bytes once it sees zero.

The register bus is an 8-bit select/write-data/write-enable port with a registered read-data output. The value on `reg_rdata` shows the register that was selected in the previous cycle. The memory side is a one-cycle request pulse with an address that is held steady. The returned word is sampled `LAT` cycles after the pulse. The memory array itself sits outside the block.

Top module: `progmem_reader`

## Requirements
- R1: The control register (select 0) reads as 8'h80 when idle and 8'h81 while a read is in progress. Bit 7 is fixed at 1, bits 6..1 are fixed at 0, and bit 0 is the read strobe.
- R2: Address-low (select 1) stores all 8 bits as word address bits 7..0. Address-high (select 2) stores bits 4..0 as word address bits 12..8. Its bits 7..5 ignore writes and read 0, so addresses 0 through 8191 are reachable.
- R3: Data-low (select 3) returns word bits 7..0. Data-high (select 4) returns word bits 13..8 in its bits 5..0, and its bits 7..6 read 0. Bus writes to either data register have no effect.
- R4: A write to the control register with bit 0 = 1 while idle starts a read. A write with bit 0 = 0 neither starts a read nor ends one in progress.
- R5: The read strobe reads back 1 for exactly LAT+1 register reads after the starting write. On completion the strobe clears and both data registers take the new word at the same edge.
- R6: Setting the strobe again while a read is in progress is ignored: no second memory request is issued and the latched address does not change.
- R7: Changing the address registers during a read leaves the fetched word unchanged. The new address values are still stored and read back.
- R8: After reset the control register reads 8'h80 and the address and data registers read 8'h00.
- R9: Each read issues exactly one single-cycle `mem_en` pulse, and `mem_addr` carries the latched address until the read completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 3 | Register select (0 control, 1 addr low, 2 addr high, 3 data low, 4 data high) |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data of the register selected last cycle |
| mem_en | output | 1 | One-cycle memory read request |
| mem_addr | output | AW | Latched word address to memory |
| mem_rdata | input | DW | Memory word, valid LAT cycles after `mem_en` |

## Verification
The bench goes after the two extreme addresses, 0 and 8191. A design that drops an address-high bit or keeps the masked bits would return the wrong word there, or read back junk in bits 7..5. It writes 0 to the strobe during idle and during a read, and writes 1 again mid-read while moving the address registers. A design that lets software clear the strobe, launches a second request, or re-reads the live address would show a wrong pulse count, an early clear or a word from the wrong location. It counts strobe readbacks cycle by cycle, so an off-by-one latency or data captured apart from the clear shows up as a wrong count or stale data.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_ALO  = 3'd1;
  localparam logic [2:0] OFS_AHI  = 3'd2;
  localparam logic [2:0] OFS_DLO  = 3'd3;
  localparam logic [2:0] OFS_DHI  = 3'd4;
  localparam logic [7:0] CTRL_FIXED = 8'h80;
endpackage

// File: rtl/pmr_regfile.sv
module pmr_regfile
  import pmr_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [2:0]    sel,
  input  logic [7:0]    wdata,
  input  logic          busy,
  output logic [AW-1:0] addr_q,
  output logic          start
);
  localparam int HW = AW - 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (we) begin
      if (sel == OFS_ALO) addr_q[7:0]    <= wdata;
      if (sel == OFS_AHI) addr_q[AW-1:8] <= wdata[HW-1:0];
    end
  end

  // set-only strobe: a 0 write or a write while busy launches nothing
  assign start = we && (sel == OFS_CTRL) && wdata[0] && !busy;
endmodule

// File: rtl/pmr_fetch.sv
module pmr_fetch #(
  parameter int AW  = 13,
  parameter int DW  = 14,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_en,
  output logic [AW-1:0] mem_addr,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] data_q
);
  logic [LAT-1:0] pipe;

  generate
    if (LAT == 1) begin : g_lat_one
      always_ff @(posedge clk) pipe <= rst ? '0 : mem_en;
    end else begin : g_lat_many
      always_ff @(posedge clk) pipe <= rst ? '0 : {pipe[LAT-2:0], mem_en};
    end
  endgenerate

  assign done = pipe[LAT-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en   <= 1'b0;
      mem_addr <= '0;
      busy     <= 1'b0;
      data_q   <= '0;
    end else begin
      mem_en <= start;
      if (start) begin
        busy     <= 1'b1;
        mem_addr <= addr_in;
      end
      if (done) begin
        busy   <= 1'b0;
        data_q <= mem_rdata;
      end
    end
  end
endmodule

// File: rtl/pmr_rdmux.sv
module pmr_rdmux
  import pmr_pkg::*;
#(
  parameter int AW = 13,
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    sel,
  input  logic          busy,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] data_q,
  output logic [7:0]    rdata
);
  logic [15:0] a16, d16;
  assign a16 = 16'(addr_q);
  assign d16 = 16'(data_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (sel)
        OFS_CTRL: rdata <= CTRL_FIXED | {7'b0, busy};
        OFS_ALO:  rdata <= a16[7:0];
        OFS_AHI:  rdata <= a16[15:8];
        OFS_DLO:  rdata <= d16[7:0];
        OFS_DHI:  rdata <= d16[15:8];
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/progmem_reader.sv
module progmem_reader #(
  parameter int AW  = 13,
  parameter int DW  = 14,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    reg_sel,
  input  logic          reg_we,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          mem_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          start, busy, done;

  pmr_regfile #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .busy(busy), .addr_q(addr_q), .start(start)
  );

  pmr_fetch #(.AW(AW), .DW(DW), .LAT(LAT)) u_fetch (
    .clk(clk), .rst(rst), .start(start), .addr_in(addr_q),
    .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_addr(mem_addr),
    .busy(busy), .done(done), .data_q(data_q)
  );

  pmr_rdmux #(.AW(AW), .DW(DW)) u_mux (
    .clk(clk), .rst(rst), .sel(reg_sel), .busy(busy),
    .addr_q(addr_q), .data_q(data_q), .rdata(reg_rdata)
  );
endmodule

// File: rtl/pmr_chk.sv
module pmr_chk
  import pmr_pkg::*;
#(
  parameter int AW  = 13,
  parameter int DW  = 14,
  parameter int LAT = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    reg_sel,
  input logic [7:0]    reg_rdata,
  input logic          mem_en,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          done
);
  logic [7:0] cnt;
  always_ff @(posedge clk) begin
    if (rst || done) cnt <= '0;
    else if (mem_en) cnt <= 8'd1;
    else if (cnt != 0) cnt <= cnt + 8'd1;
  end

  a_r1_ctrl_fixed: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(reg_sel) == OFS_CTRL) |-> (reg_rdata[7:1] == 7'b1000000));

  a_r2_ahi_mask: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(reg_sel) == OFS_AHI) |-> ((reg_rdata >> (AW-8)) == 8'd0));

  a_r3_dhi_mask: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(reg_sel) == OFS_DHI) |-> ((reg_rdata >> (DW-8)) == 8'd0));

  a_r5_clear_on_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(done));

  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (cnt == 8'(LAT)));

  a_r6_single_launch: assert property (@(posedge clk) disable iff (rst)
    mem_en |=> (!mem_en && busy));

  a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> $stable(mem_addr));
endmodule

bind progmem_reader pmr_chk #(.AW(AW), .DW(DW), .LAT(LAT)) u_chk (
  .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
  .mem_en(mem_en), .mem_addr(mem_addr), .busy(busy), .done(done)
);

// File: tb/progmem_reader_test.sv
module progmem_reader_test;
  localparam int AW = 13, DW = 14, LAT = 2;

  logic          clk = 1'b0, rst = 1'b1;
  logic [2:0]    reg_sel = '0;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          mem_en;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] m1 = '0, m2 = '0;
  int n_chk = 0, n_err = 0, n_en = 0;
  logic [AW-1:0] last_req = '0;

  always #2 clk = ~clk;

  progmem_reader #(.AW(AW), .DW(DW), .LAT(LAT)) uut (.*);

  function automatic logic [13:0] mw(input logic [12:0] a);
    logic [13:0] x;
    x = {1'b0, a};
    return (x * 14'd29) ^ {x[6:0], x[13:7]} ^ 14'h2C5B;
  endfunction

  // behavioural memory, two-stage read
  always @(posedge clk) begin
    if (mem_en) m1 <= mw(mem_addr);
    m2 <= m1;
    if (!rst && mem_en) begin n_en <= n_en + 1; last_req <= mem_addr; end
  end
  assign mem_rdata = m2;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks enter and leave at a falling edge
  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    reg_sel = s; reg_we = 1'b1; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    reg_sel = s;
    @(posedge clk); @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic set_addr(input logic [12:0] a);
    wr(3'd1, a[7:0]);
    wr(3'd2, {3'b0, a[12:8]});
  endtask

  task automatic check_data(input string tag, input logic [12:0] a);
    logic [7:0] v;
    logic [13:0] w;
    w = mw(a);
    rd(3'd3, v); chk(tag, {8'h0, v}, {8'h0, w[7:0]});
    rd(3'd4, v); chk(tag, {8'h0, v}, {10'h0, w[13:8]});
  endtask

  // precise read: strobe reads 1 for LAT+1 polls, then 0
  task automatic timed_read(input logic [12:0] a);
    logic [7:0] v;
    int en0, busy_n;
    en0 = n_en;
    set_addr(a);
    wr(3'd0, 8'h01);
    busy_n = 0;
    for (int k = 0; k < LAT + 3; k++) begin
      rd(3'd0, v);
      if (k <= LAT) chk("R1 strobe while busy", {8'h0, v}, 16'h0081);
      if (v[0]) busy_n++;
    end
    chk("R5 strobe duration", 16'(busy_n), 16'(LAT + 1));
    chk("R9 one request", 16'(n_en - en0), 16'd1);
    chk("R9 request address", {3'b0, last_req}, {3'b0, a});
    check_data("R3 data word", a);
  endtask

  initial begin
    logic [7:0] v;
    int en0;
    logic [12:0] a;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R8 reset values
    rd(3'd0, v); chk("R8 ctrl reset", {8'h0, v}, 16'h0080);
    for (int s = 1; s <= 4; s++) begin
      rd(3'(s), v); chk("R8 reg reset", {8'h0, v}, 16'h0000);
    end

    // R4 zero writes launch nothing
    en0 = n_en;
    wr(3'd0, 8'h00); wr(3'd0, 8'hFE);
    rd(3'd0, v); chk("R4 zero write idle", {8'h0, v}, 16'h0080);
    repeat (4) rd(3'd0, v);
    chk("R4 no request", 16'(n_en - en0), 16'd0);

    // R2 masking
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    rd(3'd1, v); chk("R2 addr low", {8'h0, v}, 16'h00FF);
    rd(3'd2, v); chk("R2 addr high mask", {8'h0, v}, 16'h001F);

    // R3 data regs read-only
    wr(3'd3, 8'hA5); wr(3'd4, 8'hFF);
    rd(3'd3, v); chk("R3 data low ro", {8'h0, v}, 16'h0000);
    rd(3'd4, v); chk("R3 data high ro", {8'h0, v}, 16'h0000);

    // extremes
    timed_read(13'h1FFF);
    timed_read(13'h0000);
    timed_read(13'h0ABC);

    // R6 R7 disturb during a read, R4 zero write mid read
    en0 = n_en;
    set_addr(13'h1234);
    wr(3'd0, 8'h01);
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h56);
    wr(3'd0, 8'h00);
    repeat (2) rd(3'd0, v);
    chk("R6 no second request", 16'(n_en - en0), 16'd1);
    check_data("R7 word from latched address", 13'h1234);
    rd(3'd1, v); chk("R7 new addr low kept", {8'h0, v}, 16'h0056);

    en0 = n_en;
    set_addr(13'h0200);
    wr(3'd0, 8'h01);
    wr(3'd0, 8'h00);
    rd(3'd0, v); chk("R4 zero write no clear", {8'h0, v}, 16'h0081);
    repeat (3) rd(3'd0, v);
    chk("R5 completes", {8'h0, v}, 16'h0080);
    check_data("R4 read after zero write", 13'h0200);

    // random addresses
    for (int i = 0; i < 40; i++) begin
      a = 13'($urandom);
      timed_read(a);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule